// File: doc/BRIEF.md
# Match-Compare Operating-System Timer

This block is a memory-mapped system timer. A single up-counter advances by one on every clock cycle in which the reference tick enable is high. Four compare channels each hold a match value. When a tick brings the counter onto a channel's value, that channel records a sticky event, and the event drives the channel's own interrupt line. A channel records the event only if its interrupt-enable bit is set. Software acknowledges events by writing ones to the status word.

Channel 3 also serves as a watchdog. Software arms it by setting bit 0 of the watchdog word. The next channel-3 match then produces a one-cycle reset request and clears the watchdog word, so the watchdog must be re-armed before it can fire again. All accesses use whole words on a simple write-strobe bus with a byte address. Reads are combinational on the address. Because address bits [1:0] are ignored, every address is treated as word-aligned.

Top module: `match_timer`

## Requirements
- R1: After the asynchronous active-low reset, every register reads 0, all interrupt lines are low, and the reset-request output is low.
- R2: While `tickEn` is high and no counter write is in progress, the counter at offset 0x10 rises by one each clock and wraps from 0xFFFFFFFF to 0. While `tickEn` is low, the counter holds its value.
- R3: A write to offset 0x10 loads the counter. In that cycle the write takes precedence over a tick, and no compare channel can match.
- R4: Match value n (n = 0..3) reads and writes at offset 4*n.
- R5: A tick that brings the counter to channel n's match value sets status bit n only when interrupt-enable bit n is 1. When that bit is 0, nothing is recorded. A match on the wrap to 0 follows the same rule.
- R6: The interrupt-enable word at offset 0x1C keeps only bits [11:0]. Upper bits read back as 0.
- R7: Writing the status word at offset 0x14 clears each bit that is written as 1 and is currently set. All other bits keep their value.
- R8: Interrupt line `irq[n]` follows status bit n. It rises in the cycle after the match edge and falls in the cycle after the clearing write.
- R9: If a status clear and a new match on the same bit land on one clock edge, the bit stays set.
- R10: If bit 0 of the watchdog word at offset 0x18 is 1 when channel 3 matches, `wdogRst` is high for exactly one cycle and the watchdog word returns to 0. This happens whatever the interrupt-enable setting is. A later match that occurs while the watchdog is disarmed produces no request.
- R11: Reads of any offset outside the eight mapped words return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Counter advance enable, one pulse per reference tick |
| wrEn | input | 1 | Write strobe for the addressed word |
| addr | input | 8 | Byte address; bits [1:0] ignored |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| irq | output | 4 | Per-channel interrupt lines |
| wdogRst | output | 1 | One-cycle reset request from the watchdog |

## Verification
The bench builds the block with its default parameters: 32-bit data, four channels, a 12-bit enable word and channel 3 as the watchdog. Because the counter can be loaded, the bench reaches the wrap at 0xFFFFFFFF in a few cycles by loading a value just below it. The same loading lets it place each match one or two ticks ahead, which brings the same-edge clear-versus-match race and the self-disarming watchdog within reach in a few hundred cycles.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

  // Register word indices (byte offset / 4); channel n match lives at word n
  localparam int unsigned MAX_CH      = 4;
  localparam int unsigned WORD_COUNT  = 4;
  localparam int unsigned WORD_STATUS = 5;
  localparam int unsigned WORD_WDOG   = 6;
  localparam int unsigned WORD_IEN    = 7;

  // Write strobes from bus control to the datapath
  typedef struct packed {
    logic              wrCount;
    logic              wrStatus;
    logic              wrWdog;
    logic              wrIen;
    logic [MAX_CH-1:0] wrMatch;
  } strobe_t;

endpackage

// File: rtl/mtmr_ctrl.sv
module mtmr_ctrl
  import mtmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned IEN_W  = 12
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              cntQ,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  matchQ,
  input  logic [NUM_CH-1:0]              statusQ,
  input  logic [DATA_W-1:0]              wdogQ,
  input  logic [IEN_W-1:0]               ienQ,
  output strobe_t                        stb,
  output logic [DATA_W-1:0]              rdData
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] wordIdx;
  logic              unusedAddrLow;

  assign wordIdx       = addr[ADDR_W-1:2];
  assign unusedAddrLow = ^addr[1:0];

  // Write decode
  always_comb begin
    stb = '0;
    if (wrEn) begin
      stb.wrCount  = (wordIdx == WORD_W'(WORD_COUNT));
      stb.wrStatus = (wordIdx == WORD_W'(WORD_STATUS));
      stb.wrWdog   = (wordIdx == WORD_W'(WORD_WDOG));
      stb.wrIen    = (wordIdx == WORD_W'(WORD_IEN));
      for (int ch = 0; ch < NUM_CH; ch++) begin
        stb.wrMatch[ch] = (wordIdx == WORD_W'(ch));
      end
    end
  end

  // Read multiplexer; unmapped words fall through to zero (R11)
  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (wordIdx == WORD_W'(ch)) rdData = matchQ[ch];
    end
    if (wordIdx == WORD_W'(WORD_COUNT))  rdData = cntQ;
    if (wordIdx == WORD_W'(WORD_STATUS)) rdData = DATA_W'(statusQ);
    if (wordIdx == WORD_W'(WORD_WDOG))   rdData = wdogQ;
    if (wordIdx == WORD_W'(WORD_IEN))    rdData = DATA_W'(ienQ);
  end

  // At most one register is written per cycle (R3, R4, R7)
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  // No strobe without a bus write
  a_r4_strobe_needs_wr: assert property (@(posedge clk) disable iff (!rstN)
    (stb != '0) |-> wrEn);

endmodule

// File: rtl/mtmr_datapath.sv
module mtmr_datapath
  import mtmr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned IEN_W   = 12,
  parameter int unsigned WDOG_CH = 3
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tickEn,
  input  strobe_t                        stb,
  input  logic [DATA_W-1:0]              wrData,
  output logic [DATA_W-1:0]              cntQ,
  output logic [NUM_CH-1:0][DATA_W-1:0]  matchQ,
  output logic [NUM_CH-1:0]              statusQ,
  output logic [DATA_W-1:0]              wdogQ,
  output logic [IEN_W-1:0]               ienQ,
  output logic [NUM_CH-1:0]              irq,
  output logic                           wdogRst
);

  logic [DATA_W-1:0] cntNext;
  logic [NUM_CH-1:0] hit;
  logic [NUM_CH-1:0] clrMask;
  logic [NUM_CH-1:0] statusD;
  logic              advance;
  logic              wdogFire;

  assign cntNext = cntQ + DATA_W'(1);
  assign advance = tickEn && !stb.wrCount;

  // Free-running up-counter; a load takes precedence over a tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (stb.wrCount) cntQ <= wrData;
    else if (tickEn)      cntQ <= cntNext;
  end

  // Per-channel match register and equality compare on the arriving count
  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              matchQ[g] <= '0;
      else if (stb.wrMatch[g]) matchQ[g] <= wrData;
    end
    assign hit[g] = advance && (cntNext == matchQ[g]);
  end

  // Interrupt enable keeps only its low IEN_W bits
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ienQ <= '0;
    else if (stb.wrIen) ienQ <= wrData[IEN_W-1:0];
  end

  // Sticky status, write-one-to-clear, a fresh match overrides the clear
  assign clrMask = stb.wrStatus ? wrData[NUM_CH-1:0] : '0;
  assign statusD = (statusQ & ~clrMask) | (hit & ienQ[NUM_CH-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= statusD;
  end

  assign irq = statusQ;

  // Self-disarming watchdog on the designated channel
  assign wdogFire = hit[WDOG_CH] && wdogQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdogQ   <= '0;
      wdogRst <= 1'b0;
    end else begin
      wdogRst <= wdogFire;
      if (wdogFire)        wdogQ <= '0;
      else if (stb.wrWdog) wdogQ <= wrData;
    end
  end

  // ---------------- assertions ----------------
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !stb.wrCount) |=> (cntQ == $past(cntQ) + DATA_W'(1)));

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !stb.wrCount) |=> $stable(cntQ));

  a_r3_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCount |=> (cntQ == $past(wrData)));

  a_r5_set_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    ((statusQ & ~$past(statusQ)) & ~$past(ienQ[NUM_CH-1:0])) == '0);

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrStatus |=> ((statusQ & $past(statusQ)) == $past(statusQ)));

  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |=> !wdogRst);

  a_r10_disarmed: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |-> (wdogQ == '0));

endmodule

// File: rtl/match_timer.sv
module match_timer
  import mtmr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned IEN_W   = 12,
  parameter int unsigned WDOG_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irq,
  output logic              wdogRst
);

  strobe_t                       stb;
  logic [DATA_W-1:0]             cntQ;
  logic [NUM_CH-1:0][DATA_W-1:0] matchQ;
  logic [NUM_CH-1:0]             statusQ;
  logic [DATA_W-1:0]             wdogQ;
  logic [IEN_W-1:0]              ienQ;

  mtmr_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .IEN_W(IEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .cntQ(cntQ), .matchQ(matchQ), .statusQ(statusQ), .wdogQ(wdogQ),
    .ienQ(ienQ), .stb(stb), .rdData(rdData)
  );

  mtmr_datapath #(
    .DATA_W(DATA_W), .NUM_CH(NUM_CH), .IEN_W(IEN_W), .WDOG_CH(WDOG_CH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .stb(stb), .wrData(wrData),
    .cntQ(cntQ), .matchQ(matchQ), .statusQ(statusQ), .wdogQ(wdogQ),
    .ienQ(ienQ), .irq(irq), .wdogRst(wdogRst)
  );

endmodule

// File: tb/match_timer_bench.sv
module match_timer_bench;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          tickEn;
  logic          wrEn;
  logic [AW-1:0] addr;
  logic [DW-1:0] wrData;
  logic [DW-1:0] rdData;
  logic [3:0]    irq;
  logic          wdogRst;

  int total = 0;
  int bad   = 0;
  int pulses = 0;

  always #2 clk = ~clk;  // 250 MHz

  match_timer u_match_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq), .wdogRst(wdogRst)
  );

  always @(negedge clk) if (rstN && wdogRst) pulses++;

  typedef enum logic [1:0] {OP_WR, OP_RD, OP_TICK} op_t;
  typedef struct packed {
    op_t         op;
    logic [7:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [0:NV-1] = '{
    '{OP_WR,   8'h1C, 32'hFFFF_FFFF, 32'h0,     8'd6},
    '{OP_RD,   8'h1C, 32'h0,         32'hFFF,   8'd6},   // R6
    '{OP_WR,   8'h10, 32'h100,       32'h0,     8'd3},
    '{OP_RD,   8'h10, 32'h0,         32'h100,   8'd3},   // R3
    '{OP_TICK, 8'h00, 32'd5,         32'h0,     8'd2},
    '{OP_RD,   8'h10, 32'h0,         32'h105,   8'd2},   // R2
    '{OP_WR,   8'h00, 32'h108,       32'h0,     8'd4},
    '{OP_WR,   8'h04, 32'h10A,       32'h0,     8'd4},
    '{OP_RD,   8'h04, 32'h0,         32'h10A,   8'd4},   // R4
    '{OP_WR,   8'h1C, 32'h1,         32'h0,     8'd5},
    '{OP_TICK, 8'h00, 32'd3,         32'h0,     8'd5},
    '{OP_RD,   8'h14, 32'h0,         32'h1,     8'd5},   // R5 enabled channel
    '{OP_TICK, 8'h00, 32'd2,         32'h0,     8'd5},
    '{OP_RD,   8'h14, 32'h0,         32'h1,     8'd5},   // R5 disabled channel
    '{OP_WR,   8'h14, 32'h2,         32'h0,     8'd7},
    '{OP_RD,   8'h14, 32'h0,         32'h1,     8'd7},   // R7 unset bit
    '{OP_WR,   8'h14, 32'h1,         32'h0,     8'd7},
    '{OP_RD,   8'h14, 32'h0,         32'h0,     8'd7},   // R7 clear
    '{OP_RD,   8'h24, 32'h0,         32'h0,     8'd11},  // R11
    '{OP_RD,   8'hC0, 32'h0,         32'h0,     8'd11}   // R11
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    addr = a;
    #1 check(rdData, e, req);
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      tickEn = 1'b1;
      @(negedge clk);
    end
    tickEn = 1'b0;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; tickEn = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check({27'd0, wdogRst, irq}, 32'h0, "R1 outputs");
    addr = 8'h10; #1 check(rdData, 32'h0, "R1 counter");
    addr = 8'h14; #1 check(rdData, 32'h0, "R1 status");
    addr = 8'h18; #1 check(rdData, 32'h0, "R1 watchdog");
    @(negedge clk); rstN = 1'b1;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        OP_WR:   wr(VECS[v].a, VECS[v].d);
        OP_RD:   rd(VECS[v].a, VECS[v].e, $sformatf("R%0d vec%0d", VECS[v].req, v));
        default: ticks(int'(VECS[v].d));
      endcase
    end

    // R2: counter holds without tick
    wr(8'h10, 32'h40);
    repeat (5) @(negedge clk);
    rd(8'h10, 32'h40, "R2 hold");

    // R8: interrupt line follows status
    wr(8'h1C, 32'h1);
    wr(8'h00, 32'h41);
    ticks(1);
    check({28'd0, irq}, 32'h1, "R8 irq rise");
    wr(8'h14, 32'h1);
    check({28'd0, irq}, 32'h0, "R8 irq fall");

    // R3: load wins over a same-cycle tick and blocks the match
    wr(8'h10, 32'h30);
    wr(8'h00, 32'h31);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h10; wrData = 32'h77; tickEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    rd(8'h10, 32'h77, "R3 load over tick");
    rd(8'h14, 32'h0, "R3 no match on load");

    // R9: clear and match on the same edge
    wr(8'h00, 32'h78);
    ticks(1);
    rd(8'h14, 32'h1, "R9 setup");
    wr(8'h10, 32'h77);
    @(negedge clk);
    wrEn = 1'b1; addr = 8'h14; wrData = 32'h1; tickEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    rd(8'h14, 32'h1, "R9 match wins");
    wr(8'h14, 32'hF);

    // R2/R5: wrap to zero, match on value 0
    wr(8'h1C, 32'h2);
    wr(8'h04, 32'h0);
    wr(8'h10, 32'hFFFF_FFFE);
    ticks(1);
    rd(8'h14, 32'h0, "R5 before wrap");
    ticks(1);
    rd(8'h10, 32'h0, "R2 wrap");
    rd(8'h14, 32'h2, "R5 match at wrap");
    wr(8'h14, 32'hF);

    // R10: watchdog fires once, independent of enable bit 3
    wr(8'h1C, 32'h7);
    wr(8'h0C, 32'h50);
    wr(8'h10, 32'h4E);
    wr(8'h18, 32'h1);
    rd(8'h18, 32'h1, "R10 armed");
    ticks(1);
    check({31'd0, wdogRst}, 32'h0, "R10 no early pulse");
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    #1 check({31'd0, wdogRst}, 32'h1, "R10 pulse high");
    addr = 8'h18; #1 check(rdData, 32'h0, "R10 self disarm");
    addr = 8'h14; #1 check(rdData, 32'h0, "R10 no status without enable");
    @(negedge clk);
    #1 check({31'd0, wdogRst}, 32'h0, "R10 pulse one cycle");
    wr(8'h10, 32'h4E);
    ticks(2);
    repeat (2) @(negedge clk);
    check(pulses, 32'd1, "R10 disarmed no repeat");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule